// File: doc/BRIEF.md
# Static Schedule Sequencer

This block enforces a fixed, precomputed execution order across a set of tasks running on different processing elements. Communication transfers between dependent tasks are treated as tasks of their own. The order comes from a schedule table that is fixed when the block is built. Each table entry either launches one task or waits for one task to report completion. The sequencer walks the entries one at a time, so launches and completions of different tasks can interleave in whatever order the offline schedule chose.

Each task has one start output line and one done input line. A start line carries a single-cycle pulse, which suits a processor interrupt input or a hardware block's go input. Done pulses are caught in a per-task sticky flag, so a task that finishes before the sequencer reaches its wait entry is not lost. A done pulse from a task that was never launched raises a one-cycle protocol error. After the last entry, a completion pulse is issued. The block then either returns to idle and waits for a new run request, or restarts at once when the repeat input is high.

Top module: `sched_seq`

## Requirements
- R1: During and right after reset, all start lines, `complete_o`, `busy_o` and `proto_err_o` are low and the sequencer is idle.
- R2: While idle, no start pulse is issued. A `run_req` sampled high in idle makes `busy_o` rise at that edge, and entry 0 is executed on the following edge, so a first start pulse appears two cycles after `run_req`.
- R3: Each table entry is `NT_IDX_W+2` bits wide, with entry 0 in the least significant bits of `SCHED`. Bits [IW-1:0] hold the task index, bit IW holds the operation (1 = start, 0 = wait for done) and bit IW+1 marks the last entry. Entries are taken in table order. A start entry takes exactly one cycle and produces a one-cycle pulse on `start_o[index]`.
- R4: A wait entry holds the sequencer in place until a done flag for its task is present. No other input advances it.
- R5: A done pulse from a launched task sets that task's sticky flag. A flag set before its wait entry is reached is kept, and the wait entry consumes and clears it one edge after the flag is seen. For a wait on task A followed by a wait on task B whose flag is already set, the next start appears four cycles after A's done pulse.
- R6: A done pulse from a task that is not running produces a one-cycle `proto_err_o` pulse on the next cycle. It sets no flag and cannot satisfy a later wait entry.
- R7: When the last entry completes, `complete_o` pulses for one cycle. For a final wait entry this happens two cycles after the done pulse. With `repeat_en` low, the sequencer then returns to idle and `busy_o` falls.
- R8: With `repeat_en` high when the last entry completes, the sequencer restarts at entry 0 without a run request. A leading start entry then pulses one cycle after `complete_o`.
- R9: At most one start line is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_req | input | 1 | Begin a pass through the table when idle |
| repeat_en | input | 1 | Restart automatically after the last entry |
| done_i | input | NT | Per-task completion pulses |
| start_o | output | NT | Per-task one-cycle launch pulses |
| complete_o | output | 1 | One-cycle pulse after the last entry |
| busy_o | output | 1 | High while walking the table |
| proto_err_o | output | 1 | One-cycle pulse on a done from a task not running |

## Verification
The default table issues back-to-back launches, a pair of waits in reverse launch order, and single launch/wait pairs. The bench drives it with several done-latency patterns.

- Balanced latencies check the basic order and the R2 and R7 timing.
- An early done from the first task combined with a slow second task separates sticky capture from a design that only samples done while waiting.
- A task that never answers until it is released by hand shows that nothing but its done advances the walk.
- Stray done pulses, both while idle and during a run before the task is launched, separate a design that rejects them from one that records them as valid completions.
- A repeat pass checks the restart timing.

// File: rtl/sched_seq_pkg.sv
// Shared types for the static schedule sequencer.
package sched_seq_pkg;
    typedef enum logic {
        OP_WAIT  = 1'b0,
        OP_START = 1'b1
    } sched_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } walk_state_e;
endpackage

// File: rtl/sched_done_capture.sv
// Per-task done capture.
// Tracks which tasks are running, keeps a sticky done flag per task, and
// flags a done pulse from a task that is not running.
// Assumes a task is not launched again in the same cycle its done arrives.
module sched_done_capture #(
    parameter int NT = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NT-1:0] done_i,
    input  logic [NT-1:0] launch_i,
    input  logic [NT-1:0] consume_i,
    output logic [NT-1:0] flag_o,
    output logic          proto_err_o
);
    logic [NT-1:0] running_q;
    logic [NT-1:0] flag_q;
    logic [NT-1:0] good_done;
    logic [NT-1:0] bad_done;

    // Split each done pulse into accepted or rejected.
    always_comb begin
        good_done = done_i & running_q;
        bad_done  = done_i & ~running_q;
    end

    // Update the running set, the sticky flags and the error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_q   <= '0;
            flag_q      <= '0;
            proto_err_o <= 1'b0;
        end else begin
            running_q   <= (running_q & ~done_i) | launch_i;
            flag_q      <= (flag_q & ~consume_i) | good_done;
            proto_err_o <= |bad_done;
        end
    end

    assign flag_o = flag_q;

    for (genvar k = 0; k < NT; k++) begin : g_chk
        // R5
        flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag_q[k]) |-> $past(running_q[k] && done_i[k]));
    end

    // R6
    err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err_o |-> $past(|done_i));
endmodule

// File: rtl/sched_table_walker.sv
// Walks the fixed schedule table one entry at a time.
// Start entries fire a one-cycle pulse. Wait entries stall until the task's
// sticky flag is present and then consume it.
// Assumes every task index in the table is below NT and one entry is last.
module sched_table_walker
    import sched_seq_pkg::*;
#(
    parameter int          NT    = 4,
    parameter int          DEPTH = 8,
    parameter int          IW    = 2,
    parameter int          EW    = IW + 2,
    parameter logic [DEPTH*EW-1:0] SCHED = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_req,
    input  logic          repeat_en,
    input  logic [NT-1:0] flag_i,
    output logic [NT-1:0] launch_o,
    output logic [NT-1:0] consume_o,
    output logic [NT-1:0] start_o,
    output logic          complete_o,
    output logic          busy_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    walk_state_e   state_q;
    logic [PW-1:0] ptr_q;
    logic [EW-1:0] entry;
    logic [IW-1:0] idx;
    sched_op_e     op;
    logic          last;
    logic          avail;
    logic          step;

    // Decode the current entry and pick out its task's flag.
    always_comb begin
        entry = SCHED[ptr_q*EW +: EW];
        idx   = entry[IW-1:0];
        op    = sched_op_e'(entry[IW]);
        last  = entry[IW+1];
        avail = 1'b0;
        for (int k = 0; k < NT; k++) begin
            if (idx == IW'(k)) avail = flag_i[k];
        end
        step = (state_q == ST_RUN) && ((op == OP_START) || avail);
    end

    // One-hot launch and consume strobes for the indexed task.
    always_comb begin
        launch_o  = '0;
        consume_o = '0;
        for (int k = 0; k < NT; k++) begin
            if (state_q == ST_RUN && idx == IW'(k)) begin
                launch_o[k]  = (op == OP_START);
                consume_o[k] = (op == OP_WAIT) && avail;
            end
        end
    end

    // Entry pointer, state and registered pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            ptr_q      <= '0;
            start_o    <= '0;
            complete_o <= 1'b0;
        end else begin
            start_o    <= launch_o;
            complete_o <= step && last;
            case (state_q)
                ST_IDLE: begin
                    if (run_req) begin
                        state_q <= ST_RUN;
                        ptr_q   <= '0;
                    end
                end
                default: begin
                    if (step) begin
                        if (last) begin
                            ptr_q <= '0;
                            if (!repeat_en) state_q <= ST_IDLE;
                        end else begin
                            ptr_q <= ptr_q + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    assign busy_o = (state_q == ST_RUN);

    // R4
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && op == OP_WAIT && !avail) |=>
        (state_q == ST_RUN && ptr_q == $past(ptr_q)));

    // R9
    start_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(start_o));

    // R7
    done_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (complete_o && !$past(repeat_en)) |-> (state_q == ST_IDLE));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && $past(state_q == ST_IDLE)) |-> (start_o == '0));
endmodule

// File: rtl/sched_seq.sv
// Static schedule sequencer top.
// Connects the table walker to the per-task done capture.
// Assumes done_i is synchronous to clk and each pulse is one cycle wide.
module sched_seq #(
    parameter int NT    = 4,
    parameter int DEPTH = 8,
    parameter int IW    = (NT > 1) ? $clog2(NT) : 1,
    parameter int EW    = IW + 2,
    parameter logic [DEPTH*EW-1:0] SCHED = 32'hB726_0154
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_req,
    input  logic          repeat_en,
    input  logic [NT-1:0] done_i,
    output logic [NT-1:0] start_o,
    output logic          complete_o,
    output logic          busy_o,
    output logic          proto_err_o
);
    logic [NT-1:0] flag;
    logic [NT-1:0] launch;
    logic [NT-1:0] consume;

    sched_table_walker #(
        .NT(NT), .DEPTH(DEPTH), .IW(IW), .EW(EW), .SCHED(SCHED)
    ) walker_i (
        .clk(clk), .rst_n(rst_n), .run_req(run_req), .repeat_en(repeat_en),
        .flag_i(flag), .launch_o(launch), .consume_o(consume),
        .start_o(start_o), .complete_o(complete_o), .busy_o(busy_o)
    );

    sched_done_capture #(.NT(NT)) capture_i (
        .clk(clk), .rst_n(rst_n), .done_i(done_i), .launch_i(launch),
        .consume_i(consume), .flag_o(flag), .proto_err_o(proto_err_o)
    );
endmodule

// File: tb/sched_seq_tb.sv
// Directed bench for the static schedule sequencer, default table:
// start0, start1, wait1, wait0, start2, wait2, start3, wait3(last).
module sched_seq_tb_top;
    localparam int NT = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run_req = 1'b0;
    logic          repeat_en = 1'b0;
    logic [NT-1:0] done_i = '0;
    logic [NT-1:0] start_o;
    logic          complete_o, busy_o, proto_err_o;

    sched_seq dut_i (
        .clk(clk), .rst_n(rst_n), .run_req(run_req), .repeat_en(repeat_en),
        .done_i(done_i), .start_o(start_o), .complete_o(complete_o),
        .busy_o(busy_o), .proto_err_o(proto_err_o)
    );

    always #5 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    int cyc = 0, run_cyc = 0, cmp_cyc = 0, cmp_cnt = 0, err_cnt = 0, multi = 0;
    int dly[NT], cnt[NT], st_cnt[NT], start_cyc[NT], done_cyc[NT];
    logic [NT-1:0] man_req = '0;
    bit run_pend = 1'b0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Responder: drives all inputs at the falling edge and logs events.
    initial begin
        for (int k = 0; k < NT; k++) begin
            dly[k] = 2; cnt[k] = 0; st_cnt[k] = 0; start_cyc[k] = 0; done_cyc[k] = 0;
        end
        forever begin
            logic [NT-1:0] dv;
            @(negedge clk);
            cyc++;
            dv = '0;
            for (int k = 0; k < NT; k++) begin
                if (cnt[k] != 0) begin
                    cnt[k]--;
                    if (cnt[k] == 0) dv[k] = 1'b1;
                end
                if (start_o[k]) begin
                    st_cnt[k]++;
                    start_cyc[k] = cyc;
                    if (dly[k] != 0) cnt[k] = dly[k];
                end
            end
            dv = dv | man_req;
            man_req = '0;
            for (int k = 0; k < NT; k++) if (dv[k]) done_cyc[k] = cyc;
            done_i = dv;
            run_req = run_pend;
            if (run_pend) run_cyc = cyc;
            run_pend = 1'b0;
            if (complete_o) begin cmp_cnt++; cmp_cyc = cyc; end
            if (proto_err_o) err_cnt++;
            if ($countones(start_o) > 1) multi++;
        end
    end

    task automatic wait_cmp(input int target);
        for (int i = 0; i < 400 && cmp_cnt < target; i++) @(posedge clk);
        repeat (3) @(posedge clk);
    endtask

    task automatic set_dly(input int d0, input int d1, input int d2, input int d3);
        dly[0] = d0; dly[1] = d1; dly[2] = d2; dly[3] = d3;
    endtask

    task automatic t_reset();
        @(posedge clk); #3;
        chk(start_o == '0 && !complete_o && !busy_o && !proto_err_o, "R1 reset outputs",
            int'({start_o, complete_o, busy_o, proto_err_o}), 0);
    endtask

    task automatic t_idle();
        repeat (10) @(posedge clk);
        chk(st_cnt[0] + st_cnt[1] + st_cnt[2] + st_cnt[3] == 0, "R2 no start while idle",
            st_cnt[0] + st_cnt[1] + st_cnt[2] + st_cnt[3], 0);
        chk(!busy_o, "R2 idle not busy", int'(busy_o), 0);
    endtask

    task automatic t_basic();
        int c0 = cmp_cnt;
        int s3 = st_cnt[3];
        set_dly(3, 2, 4, 3);
        @(posedge clk); run_pend = 1'b1;
        wait_cmp(c0 + 1);
        chk(start_cyc[0] == run_cyc + 2, "R2 first start latency", start_cyc[0], run_cyc + 2);
        chk(start_cyc[1] == start_cyc[0] + 1, "R3 back-to-back starts", start_cyc[1], start_cyc[0] + 1);
        chk(start_cyc[2] > done_cyc[0] && start_cyc[2] > done_cyc[1], "R4 start2 after waits",
            start_cyc[2], done_cyc[1] + 1);
        chk(start_cyc[3] == done_cyc[2] + 3, "R3 start3 after wait2", start_cyc[3], done_cyc[2] + 3);
        chk(st_cnt[3] == s3 + 1, "R3 one pulse per start entry", st_cnt[3], s3 + 1);
        chk(cmp_cyc == done_cyc[3] + 2, "R7 complete latency", cmp_cyc, done_cyc[3] + 2);
        chk(cmp_cnt == c0 + 1, "R7 single complete pulse", cmp_cnt, c0 + 1);
        chk(!busy_o, "R7 back to idle", int'(busy_o), 0);
        chk(multi == 0, "R9 one start at a time", multi, 0);
    endtask

    task automatic t_early();
        int c0 = cmp_cnt;
        set_dly(1, 8, 2, 2);
        @(posedge clk); run_pend = 1'b1;
        wait_cmp(c0 + 1);
        chk(done_cyc[0] < done_cyc[1], "R5 done0 arrives early", done_cyc[0], done_cyc[1] - 1);
        chk(start_cyc[2] == done_cyc[1] + 4, "R5 early done kept", start_cyc[2], done_cyc[1] + 4);
        chk(cmp_cnt == c0 + 1, "R5 run completes", cmp_cnt, c0 + 1);
    endtask

    task automatic t_stall();
        int c0 = cmp_cnt;
        int s3 = st_cnt[3];
        set_dly(2, 2, 0, 2);
        @(posedge clk); run_pend = 1'b1;
        repeat (40) @(posedge clk);
        chk(st_cnt[3] == s3, "R4 wait holds without done", st_cnt[3], s3);
        chk(busy_o == 1'b1 && cmp_cnt == c0, "R4 still busy", cmp_cnt, c0);
        man_req = 4'b0100;
        wait_cmp(c0 + 1);
        chk(start_cyc[3] == done_cyc[2] + 3, "R4 release on done", start_cyc[3], done_cyc[2] + 3);
        chk(cmp_cnt == c0 + 1, "R4 completes after release", cmp_cnt, c0 + 1);
    endtask

    task automatic t_proto_idle();
        int e0 = err_cnt;
        int c0 = cmp_cnt;
        @(posedge clk); man_req = 4'b1000;
        repeat (4) @(posedge clk);
        chk(err_cnt == e0 + 1, "R6 stray done while idle", err_cnt, e0 + 1);
        chk(!busy_o && cmp_cnt == c0, "R6 stray done no effect", cmp_cnt, c0);
    endtask

    task automatic t_proto_run();
        int e0 = err_cnt;
        int c0 = cmp_cnt;
        int s0 = st_cnt[0];
        set_dly(2, 2, 2, 6);
        @(posedge clk); run_pend = 1'b1;
        for (int i = 0; i < 20 && st_cnt[0] == s0; i++) @(posedge clk);
        man_req = 4'b1000;
        wait_cmp(c0 + 1);
        chk(err_cnt == e0 + 1, "R6 stray done during run", err_cnt, e0 + 1);
        chk(cmp_cyc == done_cyc[3] + 2 && done_cyc[3] == start_cyc[3] + 6,
            "R6 stray done not captured", cmp_cyc, start_cyc[3] + 8);
    endtask

    task automatic t_repeat();
        int c0 = cmp_cnt;
        int s0 = st_cnt[0];
        int cfirst;
        set_dly(2, 2, 2, 2);
        repeat_en = 1'b1;
        @(posedge clk); run_pend = 1'b1;
        for (int i = 0; i < 400 && cmp_cnt < c0 + 1; i++) @(posedge clk);
        cfirst = cmp_cyc;
        repeat (2) @(posedge clk);
        chk(start_cyc[0] == cfirst + 1, "R8 restart without request", start_cyc[0], cfirst + 1);
        chk(busy_o == 1'b1, "R8 busy through restart", int'(busy_o), 1);
        repeat_en = 1'b0;
        wait_cmp(c0 + 2);
        chk(st_cnt[0] == s0 + 2 && !busy_o, "R8 two passes then idle", st_cnt[0], s0 + 2);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        #2 rst_n = 1'b1;
        t_idle();
        t_basic();
        t_early();
        t_stall();
        t_proto_idle();
        t_proto_run();
        t_repeat();
        chk(multi == 0, "R9 overall one-hot starts", multi, 0);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: an expired limit counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule